// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps one status byte for every transmission the transmitter finishes. The byte says whether the host asked for an interrupt on success, and whether the frame ended in jabber, underrun or too many collisions. The host reads the oldest byte from a single status port. A host write to that same port discards the byte that is showing and brings the next one forward. While any byte is waiting, a transmit-complete interrupt request stays asserted.

The store holds `DEPTH` entries (4 by default). A completion that arrives while the store is full is not kept. Instead, the overflow bit of the newest stored entry is set, so the host learns that at least one event was lost.

Jabber and underrun completions lock the transmitter off. A separate FIFO overrun input raises an adapter-failure flag, which also holds the transmitter off. Only a transmit reset clears these conditions, and the same reset empties the store.

Top module: `txstk_top`

## Requirements
- R1: After reset, `statusByte` is 0x00 and `txCompleteIrq`, `txDisabled` and `adapterFail` are all 0.
- R2: An accepted completion (`cmplValid` high for one cycle) stores a byte laid out as: bit 7 = 1 (complete), bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow (0 when stored), bits 1..0 = 0. The byte is visible on `statusByte` in the cycle after the clock edge, once it is the oldest entry.
- R3: Entries are presented oldest first. A `hostWrite` removes the presented entry at the clock edge. A `hostWrite` to an empty store has no effect.
- R4: A completion that arrives when `DEPTH` entries are held, with no pop in the same cycle, is dropped. Bit 2 of the newest held entry becomes 1, and all other entries are unchanged.
- R5: An empty store reads as 0x00 on `statusByte`, so the complete bit is 0.
- R6: `txCompleteIrq` is 1 exactly when at least one entry is held.
- R7: A completion carrying jabber or underrun sets `txDisabled` from the next cycle, whether or not the entry was stored. `txDisabled` stays 1 until `txReset`.
- R8: A pulse on `fifoOverrun` sets `adapterFail` and `txDisabled` from the next cycle. Both hold until `txReset`.
- R9: `txReset` empties the store and clears `txDisabled` and `adapterFail` at the next edge. It takes priority over a completion, pop or overrun in the same cycle.
- R10: When the store is full and a completion and a `hostWrite` come in the same cycle, the oldest entry is removed and the new one is stored with bit 2 = 0. The store stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txReset | input | 1 | Synchronous transmit reset: empties the store and clears the locks |
| cmplValid | input | 1 | One-cycle completion event from the transmitter |
| cmplIntReq | input | 1 | Interrupt requested on success for this completion |
| cmplJabber | input | 1 | Completion ended in jabber |
| cmplUnderrun | input | 1 | Completion ended in underrun |
| cmplMaxColl | input | 1 | Completion hit the maximum collision count |
| fifoOverrun | input | 1 | Transmit FIFO overrun pulse |
| hostWrite | input | 1 | Host write strobe to the status port (pops the oldest entry) |
| statusByte | output | 8 | Oldest status byte, or 0x00 when empty |
| txCompleteIrq | output | 1 | Transmit-complete interrupt request |
| txDisabled | output | 1 | Transmitter held off by a jabber, underrun or overrun |
| adapterFail | output | 1 | Adapter failure caused by a FIFO overrun |

## Verification
Some rules are checked by the assertions on every cycle:
- the entry count never exceeds `DEPTH`;
- a pop on an empty store leaves it empty;
- a full store stays full when a push and a pop meet;
- the lock and failure flags persist until a transmit reset, and that reset clears everything;
- a freshly stored entry has a clear overflow bit, and a marked entry has it set;
- the interrupt request agrees with the complete bit.

Other behaviour only the bench can show, because it depends on the order of whole event sequences:
- that bytes come out in arrival order with their exact flag layout;
- that the overflow mark lands on the newest entry and on no other;
- that a dropped jabber event still locks the transmitter.

// File: rtl/txstk_pkg.sv
package txstk_pkg;

  // Flag part of one stored entry; packed order matches status bits 6..2.
  typedef struct packed {
    logic intReq;
    logic jabber;
    logic underrun;
    logic maxColl;
    logic overflow;
  } statusEntry_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;
    logic markOvf;
  } stackStrobes_t;

endpackage

// File: rtl/txstk_ctrl.sv
module txstk_ctrl
  import txstk_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       txReset,
  input  logic                       cmplValid,
  input  logic                       cmplFatal,
  input  logic                       hostWrite,
  input  logic                       fifoOverrun,
  output stackStrobes_t              strobes,
  output logic [$clog2(DEPTH)-1:0]   wrIdx,
  output logic [$clog2(DEPTH)-1:0]   rdIdx,
  output logic [$clog2(DEPTH)-1:0]   lastIdx,
  output logic                       notEmpty,
  output logic                       txDisabled,
  output logic                       adapterFail
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [CNT_W-1:0] countQ;
  logic [PTR_W-1:0] wrPtrQ, rdPtrQ;
  logic             lockQ, failQ;
  logic             popEn, pushEn, isFull;

  function automatic logic [PTR_W-1:0] bumpIdx(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  assign isFull   = (countQ == FULL_CNT);
  assign notEmpty = (countQ != '0);
  assign popEn    = !txReset && hostWrite && notEmpty;
  assign pushEn   = !txReset && cmplValid && (!isFull || popEn);

  always_comb begin
    strobes.push    = pushEn;
    strobes.markOvf = !txReset && cmplValid && isFull && !popEn;
  end

  assign wrIdx   = wrPtrQ;
  assign rdIdx   = rdPtrQ;
  assign lastIdx = (wrPtrQ == '0) ? LAST_SLOT : wrPtrQ - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      lockQ  <= 1'b0;
      failQ  <= 1'b0;
    end else if (txReset) begin
      countQ <= '0;
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      lockQ  <= 1'b0;
      failQ  <= 1'b0;
    end else begin
      if (pushEn) wrPtrQ <= bumpIdx(wrPtrQ);
      if (popEn)  rdPtrQ <= bumpIdx(rdPtrQ);
      if (pushEn && !popEn)      countQ <= countQ + 1'b1;
      else if (popEn && !pushEn) countQ <= countQ - 1'b1;
      if (cmplValid && cmplFatal) lockQ <= 1'b1;
      if (fifoOverrun)            failQ <= 1'b1;
    end
  end

  assign txDisabled  = lockQ || failQ;
  assign adapterFail = failQ;

  // R4: the store never holds more than DEPTH entries
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= FULL_CNT);
  // R3: a pop on an empty store changes nothing
  a_r3_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == '0 && hostWrite && !cmplValid && !txReset) |=> countQ == '0);
  // R10: push and pop on a full store keep it full
  a_r10_full_swap: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && cmplValid && hostWrite && !txReset) |=> countQ == FULL_CNT);
  // R9: transmit reset empties and unlocks
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    txReset |=> (countQ == '0 && !txDisabled && !adapterFail));
  // R7: the lock holds until a transmit reset
  a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !txReset) |=> lockQ);
  // R7: a fatal completion locks the transmitter
  a_r7_lock_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cmplValid && cmplFatal && !txReset) |=> txDisabled);
  // R8: the failure holds until a transmit reset
  a_r8_fail_holds: assert property (@(posedge clk) disable iff (!rstN)
    (failQ && !txReset) |=> (failQ && txDisabled));

endmodule

// File: rtl/txstk_data.sv
module txstk_data
  import txstk_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stackStrobes_t            strobes,
  input  statusEntry_t             newEntry,
  input  logic [$clog2(DEPTH)-1:0] wrIdx,
  input  logic [$clog2(DEPTH)-1:0] rdIdx,
  input  logic [$clog2(DEPTH)-1:0] lastIdx,
  output statusEntry_t             headEntry
);
  localparam int PTR_W = $clog2(DEPTH);

  statusEntry_t slotQ [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ[i] <= '0;
      end else if (strobes.push && wrIdx == PTR_W'(i)) begin
        slotQ[i] <= newEntry;
      end else if (strobes.markOvf && lastIdx == PTR_W'(i)) begin
        slotQ[i].overflow <= 1'b1;
      end
    end
  end

  assign headEntry = slotQ[rdIdx];

  // R2: a freshly written entry carries a clear overflow bit
  a_r2_fresh_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |=> !slotQ[$past(wrIdx)].overflow);
  // R4: a dropped event marks the newest entry
  a_r4_mark_newest: assert property (@(posedge clk) disable iff (!rstN)
    strobes.markOvf |=> slotQ[$past(lastIdx)].overflow);
  // R4: push and mark are never requested together
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.push && strobes.markOvf));

endmodule

// File: rtl/txstk_top.sv
module txstk_top
  import txstk_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txReset,
  input  logic       cmplValid,
  input  logic       cmplIntReq,
  input  logic       cmplJabber,
  input  logic       cmplUnderrun,
  input  logic       cmplMaxColl,
  input  logic       fifoOverrun,
  input  logic       hostWrite,
  output logic [7:0] statusByte,
  output logic       txCompleteIrq,
  output logic       txDisabled,
  output logic       adapterFail
);
  localparam int PTR_W = $clog2(DEPTH);

  stackStrobes_t    strobes;
  statusEntry_t     newEntry, headEntry;
  logic [PTR_W-1:0] wrIdx, rdIdx, lastIdx;
  logic             notEmpty;

  always_comb begin
    newEntry.intReq   = cmplIntReq;
    newEntry.jabber   = cmplJabber;
    newEntry.underrun = cmplUnderrun;
    newEntry.maxColl  = cmplMaxColl;
    newEntry.overflow = 1'b0;
  end

  txstk_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .txReset(txReset),
    .cmplValid(cmplValid), .cmplFatal(cmplJabber | cmplUnderrun),
    .hostWrite(hostWrite), .fifoOverrun(fifoOverrun),
    .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx), .lastIdx(lastIdx),
    .notEmpty(notEmpty), .txDisabled(txDisabled), .adapterFail(adapterFail)
  );

  txstk_data #(.DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .newEntry(newEntry),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .lastIdx(lastIdx), .headEntry(headEntry)
  );

  assign statusByte    = notEmpty ? {1'b1, headEntry, 2'b00} : 8'h00;
  assign txCompleteIrq = notEmpty;

  // R5: no pending entry means a zero status byte
  a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    !txCompleteIrq |-> statusByte == 8'h00);
  // R6: the interrupt request goes with a set complete bit
  a_r6_irq_complete: assert property (@(posedge clk) disable iff (!rstN)
    txCompleteIrq |-> statusByte[7]);

endmodule

// File: tb/txstk_tb_top.sv
module txstk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txReset = 0, cmplValid = 0, cmplIntReq = 0, cmplJabber = 0;
  logic cmplUnderrun = 0, cmplMaxColl = 0, fifoOverrun = 0, hostWrite = 0;
  logic [7:0] statusByte;
  logic txCompleteIrq, txDisabled, adapterFail;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] modelQ[$];
  logic modelLock = 0, modelFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txstk_top #(.DEPTH(DEPTH)) dut_i (.*);

  function automatic logic [7:0] mkByte(logic ir, logic j, logic u, logic m);
    return {1'b1, ir, j, u, m, 3'b000};
  endfunction

  function automatic logic [7:0] expByte();
    return (modelQ.size() > 0) ? modelQ[0] : 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  function automatic void modelEdge();
    bit popOk, fullNow;
    if (txReset) begin
      modelQ.delete();
      modelLock = 0;
      modelFail = 0;
      return;
    end
    if (fifoOverrun) modelFail = 1;
    if (cmplValid && (cmplJabber || cmplUnderrun)) modelLock = 1;
    popOk   = hostWrite && modelQ.size() > 0;
    fullNow = modelQ.size() == DEPTH;
    if (popOk) void'(modelQ.pop_front());
    if (cmplValid) begin
      if (!fullNow || popOk)
        modelQ.push_back(mkByte(cmplIntReq, cmplJabber, cmplUnderrun, cmplMaxColl));
      else
        modelQ[modelQ.size()-1] = modelQ[modelQ.size()-1] | 8'h04;
    end
  endfunction

  task automatic step(logic v, logic ir, logic j, logic u, logic m,
                      logic wr, logic ovr, logic rst);
    cmplValid = v; cmplIntReq = ir; cmplJabber = j; cmplUnderrun = u;
    cmplMaxColl = m; hostWrite = wr; fifoOverrun = ovr; txReset = rst;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    cmplValid = 0; hostWrite = 0; fifoOverrun = 0; txReset = 0;
  endtask

  task automatic cmpAll(string tagByte);
    chk(tagByte, statusByte, expByte());
    chk("R6 irq", {7'b0, txCompleteIrq}, {7'b0, modelQ.size() > 0});
    chk("R7 disabled", {7'b0, txDisabled}, {7'b0, modelLock | modelFail});
    chk("R8 adapterFail", {7'b0, adapterFail}, {7'b0, modelFail});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state, R5 empty reads zero
    chk("R1 byte", statusByte, 8'h00);
    chk("R1 irq", {7'b0, txCompleteIrq}, 8'h00);
    chk("R1 disabled", {7'b0, txDisabled}, 8'h00);
    chk("R1 fail", {7'b0, adapterFail}, 8'h00);
    chk("R5 empty", statusByte, 8'h00);

    // R2 layout: intReq+maxColl -> 0xC8
    step(1, 1, 0, 0, 1, 0, 0, 0);
    chk("R2 layout", statusByte, 8'hC8);
    chk("R6 irq set", {7'b0, txCompleteIrq}, 8'h01);
    // R3 pop then empty write ignored
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R3 pop to empty", statusByte, 8'h00);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R3 write on empty", statusByte, 8'h00);
    chk("R3 write on empty irq", {7'b0, txCompleteIrq}, 8'h00);

    // R3 order and R4 overflow mark
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 1, 0, 0, 0);
    step(1, 1, 0, 0, 1, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0, 0); // dropped, jabber still locks
    chk("R7 dropped jabber locks", {7'b0, txDisabled}, 8'h01);
    chk("R3 oldest", statusByte, 8'h80);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R3 second", statusByte, 8'hC0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R4 untouched older", statusByte, 8'h88);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R4 newest marked", statusByte, 8'hCC);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R5 empty after drain", statusByte, 8'h00);

    // R9 reset clears lock and store, wins over same-cycle events
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 1, 1);
    chk("R9 store empty", statusByte, 8'h00);
    chk("R9 unlocked", {7'b0, txDisabled}, 8'h00);
    chk("R9 fail clear", {7'b0, adapterFail}, 8'h00);

    // R10 full push+pop
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 1, 1, 0, 0);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R10 swapped entry no ovf", statusByte, 8'hC8);
    step(0, 0, 0, 0, 0, 1, 0, 0);

    // R8 overrun
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 fail set", {7'b0, adapterFail}, 8'h01);
    chk("R8 disabled", {7'b0, txDisabled}, 8'h01);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 fail holds", {7'b0, adapterFail}, 8'h01);
    step(0, 0, 0, 0, 0, 0, 0, 1);

    // Random mix, full model comparison each cycle (R2 R3 R4 R10)
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[1:0] != 0, r[2], r[3] & r[4] & r[5], r[6] & r[7] & r[8], r[9],
           r[11:10] == 0, (r[19:12] == 0), (r[27:20] == 0));
      cmpAll("R2 random byte");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule